// File: doc/BRIEF.md
# CAN Error Flag Capture Unit

This block records CAN protocol error events as seven sticky flags. The protocol engine supplies one single-cycle strobe for each error type. Each flag holds its value until software clears it. The flags appear at bits 14 to 8 of a 16-bit status word, and every other bit of that word reads as zero.

A control bit selects how errors are recorded.
- **First-error mode** (the reset default): the unit keeps only the earliest error event. If several strobes arrive in that same first cycle, all of them are kept. Every later strobe is dropped until software has cleared all seven flags.
- **All-errors mode**: every strobe sets its flag.

The control bit can be changed only while the channel reports reset or halt. At any other time a write to it is ignored.

A small host port reads and writes two words, selected by one bit: the control word and the status word. Software clears a flag by writing 0 to its position in the status word. Writing 1 leaves the flag as it is. Read data is registered and returns one cycle after the select is presented.

Top module: `can_errcap`

## Requirements
- R1: After a synchronous reset, every flag is 0, the control bit is 0 (first-error mode), and both `status_o` and `bus_rdata_o` are 0.
- R2: `status_o` holds the flags at bits 8..14. In order, these are stuff (bit 8), form (9), ACK (10), CRC (11), recessive-bit (12), dominant-bit (13) and ACK-delimiter (14). These follow strobe bits 0..6 of `err_evt_i`. Bits 15 and 7..0 are always 0, and writes to them have no effect.
- R3: In first-error mode, while any flag is set, no strobe sets a flag. A flag set by a strobe is visible on `status_o` after the clock edge that samples the strobe.
- R4: In first-error mode with all flags clear, every strobe asserted in the same cycle sets its flag.
- R5: In first-error mode, once all flags have been cleared, the next strobe is recorded again.
- R6: In all-errors mode (control bit 1), every strobe sets its flag, whatever flags are already set.
- R7: A write to the control word (`bus_sel_i`=0) loads bit 0 of `bus_wdata_i` as the mode bit only when `chan_reset_i` or `chan_halt_i` is high. Otherwise the write is ignored.
- R8: A write to the status word (`bus_sel_i`=1) clears each flag whose bit in `bus_wdata_i[14:8]` is 0. A 1 leaves the flag unchanged. With no such write, no flag ever clears.
- R9: A strobe and a clear in the same cycle leave the flag set. In first-error mode, a clear that empties every flag also lets a strobe in that same cycle be recorded.
- R10: `bus_rdata_o` returns, one cycle after the select, the control word (mode at bit 0, other bits 0) for select 0 or the status word for select 1. The value reflects state before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt_i | input | 7 | Single-cycle error strobes, bit 0 stuff .. bit 6 ACK delimiter |
| chan_reset_i | input | 1 | Channel is in reset mode |
| chan_halt_i | input | 1 | Channel is in halt mode |
| bus_wr_i | input | 1 | Host write strobe |
| bus_sel_i | input | 1 | Word select: 0 control, 1 status |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Registered read data |
| status_o | output | 16 | Status word with flags at bits 14..8 |

## Verification
The main function is exercised with several strobe patterns:
- a lone first strobe, which tells recording apart from ignoring;
- a later strobe on another flag while a flag is held, which separates first-error from all-errors behaviour;
- two simultaneous first strobes, which shows whether one or all of them are kept;
- a strobe in the same cycle as a clear, on the same flag and on a different flag, which checks the priority between the two and when the empty condition is evaluated.

Mode writes are tried with and without the reset and halt indicators, and the mode is then read back through the control word. Clear writes use all ones, selective zeros and junk in the unused bits.

// File: rtl/can_errcap_pkg.sv
package can_errcap_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } word_sel_e;

  localparam int unsigned ERR_KINDS = 7;
endpackage

// File: rtl/errcap_mode_reg.sv
module errcap_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic chan_reset,
  input  logic chan_halt,
  output logic mode_o
);
  logic unlocked;

  assign unlocked = chan_reset | chan_halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= 1'b0;
    end else if (wr_en && unlocked) begin
      mode_o <= wr_bit;
    end
  end
endmodule

// File: rtl/errcap_flag_bank.sv
module errcap_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr_mask,
  input  logic         capture_all,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] survivors;
  logic         accept;

  // Emptiness is judged after this cycle's clear, so a clear that empties the
  // bank lets a strobe in the same cycle be recorded.
  assign survivors = flags_o & ~clr_mask;
  assign accept    = capture_all | ~(|survivors);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_o[i] <= 1'b0;
      end else if (evt[i] && accept) begin
        flags_o[i] <= 1'b1;
      end else if (clr_mask[i]) begin
        flags_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/errcap_read_port.sv
module errcap_read_port #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] ctrl_word,
  input  logic [W-1:0] stat_word,
  output logic [W-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= sel ? stat_word : ctrl_word;
    end
  end
endmodule

// File: rtl/can_errcap.sv
module can_errcap #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned NUM_ERR  = can_errcap_pkg::ERR_KINDS,
  parameter int unsigned FLAG_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic              chan_reset_i,
  input  logic              chan_halt_i,
  input  logic              bus_wr_i,
  input  logic              bus_sel_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic [WORD_W-1:0] status_o
);
  import can_errcap_pkg::*;

  logic               mode_q;
  logic [NUM_ERR-1:0] flags_q;
  logic [NUM_ERR-1:0] clr_mask;
  logic               wr_ctrl;
  logic               wr_stat;
  logic [WORD_W-1:0]  ctrl_word;
  logic [WORD_W-1:0]  stat_word;

  assign wr_ctrl  = bus_wr_i && (bus_sel_i == SEL_CTRL);
  assign wr_stat  = bus_wr_i && (bus_sel_i == SEL_STAT);
  assign clr_mask = wr_stat ? ~bus_wdata_i[FLAG_LSB +: NUM_ERR] : '0;

  errcap_mode_reg u_mode (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_ctrl),
    .wr_bit     (bus_wdata_i[0]),
    .chan_reset (chan_reset_i),
    .chan_halt  (chan_halt_i),
    .mode_o     (mode_q)
  );

  errcap_flag_bank #(.N(NUM_ERR)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .evt         (err_evt_i),
    .clr_mask    (clr_mask),
    .capture_all (mode_q),
    .flags_o     (flags_q)
  );

  assign stat_word = WORD_W'(flags_q) << FLAG_LSB;
  assign ctrl_word = WORD_W'(mode_q);

  errcap_read_port #(.W(WORD_W)) u_read (
    .clk       (clk),
    .rst       (rst),
    .sel       (bus_sel_i),
    .ctrl_word (ctrl_word),
    .stat_word (stat_word),
    .rdata_o   (bus_rdata_o)
  );

  assign status_o = stat_word;
endmodule

// File: rtl/can_errcap_checker.sv
module can_errcap_checker #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned NUM_ERR  = 7,
  parameter int unsigned FLAG_LSB = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_ERR-1:0] err_evt_i,
  input logic               chan_reset_i,
  input logic               chan_halt_i,
  input logic               bus_wr_i,
  input logic               bus_sel_i,
  input logic               mode_q,
  input logic [WORD_W-1:0]  status_o
);
  logic [NUM_ERR-1:0] fl;
  logic               rst_d = 1'b0;

  assign fl = status_o[FLAG_LSB +: NUM_ERR];

  always @(posedge clk) rst_d <= rst;

  // R1: state observed one edge after a reset cycle is all zero
  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clean_R1: assert (status_o == '0 && mode_q == 1'b0);
    end
  end

  // R2: unused status bits stay zero
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (status_o & ~(WORD_W'({NUM_ERR{1'b1}}) << FLAG_LSB)) == '0);

  // R3: held flags freeze in first-error mode without a clear write
  assert_first_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && (|fl) && !(bus_wr_i && bus_sel_i)) |=> (fl == $past(fl)));

  // R6: every strobe in all-errors mode lands
  assert_all_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q && (|err_evt_i)) |=> ((fl & $past(err_evt_i)) == $past(err_evt_i)));

  // R7: mode is locked outside reset and halt
  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (rst)
    !(chan_reset_i || chan_halt_i) |=> $stable(mode_q));

  // R8: no flag falls without a status-word write
  assert_no_spurious_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_i && bus_sel_i) |=> ((fl & $past(fl)) == $past(fl)));
endmodule

bind can_errcap can_errcap_checker #(
  .WORD_W   (WORD_W),
  .NUM_ERR  (NUM_ERR),
  .FLAG_LSB (FLAG_LSB)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .err_evt_i    (err_evt_i),
  .chan_reset_i (chan_reset_i),
  .chan_halt_i  (chan_halt_i),
  .bus_wr_i     (bus_wr_i),
  .bus_sel_i    (bus_sel_i),
  .mode_q       (mode_q),
  .status_o     (status_o)
);

// File: tb/can_errcap_test.sv
module can_errcap_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  err_evt_i = '0;
  logic        chan_reset_i = 1'b0;
  logic        chan_halt_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_sel_i = 1'b1;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [15:0] status_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] stat;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  logic [6:0] m_flags = '0;
  logic       m_mode  = 1'b0;

  always #4 clk = ~clk;

  can_errcap uut (
    .clk          (clk),
    .rst          (rst),
    .err_evt_i    (err_evt_i),
    .chan_reset_i (chan_reset_i),
    .chan_halt_i  (chan_halt_i),
    .bus_wr_i     (bus_wr_i),
    .bus_sel_i    (bus_sel_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .status_o     (status_o)
  );

  function automatic logic [15:0] pack(input logic [6:0] f);
    return {1'b0, f, 8'h00};
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic [6:0] evt, input logic wr, input logic sel,
                      input logic [15:0] wd, input logic rch, input logic hch,
                      input string tag);
    exp_t e;
    logic [6:0] clr;
    logic [6:0] keep;
    logic       acc;
    @(negedge clk);
    err_evt_i    = evt;
    bus_wr_i     = wr;
    bus_sel_i    = sel;
    bus_wdata_i  = wd;
    chan_reset_i = rch;
    chan_halt_i  = hch;
    e.rd  = sel ? pack(m_flags) : {15'b0, m_mode};
    clr   = (wr && sel) ? ~wd[14:8] : 7'h00;
    keep  = m_flags & ~clr;
    acc   = m_mode || (keep == 7'h00);
    m_flags = keep | (acc ? evt : 7'h00);
    if (wr && !sel && (rch || hch)) m_mode = wd[0];
    e.stat = pack(m_flags);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(7'h00, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares after each edge, well away from it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "status", status_o, e.stat);
        cmp(e.tag, "rdata", bus_rdata_o, e.rd);
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cmp("R1", "status after reset", status_o, 16'h0000);
    cmp("R1", "rdata after reset", bus_rdata_o, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // R1: control word reads first-error mode after reset
    step(7'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R1 mode");
    // R3/R2: lone stuff error lands at bit 8
    step(7'h01, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R3 first");
    step(7'h02, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R3 later ignored");
    // R8: writing ones keeps flags
    step(7'h00, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, "R8 write ones");
    step(7'h00, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R8 clear");
    // R4: two simultaneous first errors
    step(7'h24, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R4 simultaneous");
    step(7'h40, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R3 held");
    // R3: partial clear leaves a flag, strobe still blocked
    step(7'h08, 1'b1, 1'b1, 16'h2000, 1'b0, 1'b0, "R3 partial clear");
    // R9: clear emptying bank plus strobe same cycle
    step(7'h10, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R9 empty+strobe");
    step(7'h00, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R8 clear all");
    // R5/R2: ACK-delimiter at bit 14 after emptying
    step(7'h40, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R5 recapture");
    // R10: read both words
    step(7'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R10 read ctrl");
    step(7'h00, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R10 read stat");
    // R2: junk in unused bits has no effect
    step(7'h00, 1'b1, 1'b1, 16'hC0FF, 1'b0, 1'b0, "R2 junk write");
    idle("R2 idle");
    step(7'h00, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R8 clear");
    // R7: mode write ignored while running
    step(7'h00, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, "R7 locked write");
    step(7'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R7 readback");
    step(7'h01, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R7 still first");
    step(7'h02, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R7 still first");
    // R7: accepted in halt
    step(7'h00, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b1, "R7 halt write");
    step(7'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R7 readback");
    // R6: all-errors mode
    step(7'h02, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R6 add form");
    step(7'h08, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R6 add CRC");
    step(7'h50, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R6 add two");
    // R9: same-flag clear and strobe
    step(7'h02, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, "R9 same flag");
    idle("R9 idle");
    // R7: accepted in reset mode, back to first-error
    step(7'h00, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, "R7 reset write");
    step(7'h20, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, "R3 first again");
    step(7'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, "R10 read ctrl");
    idle("R10 idle");
    idle("R10 idle");

    @(posedge clk);
    #3;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule